// File: doc/BRIEF.md
# Stereo Sample Buffer with Status Flags

This block buffers compressed audio samples between a host bus and a decoder that draws samples at the playback rate. It runs either as a single mono FIFO or as two FIFOs, left and right, for stereo. The capacity of each FIFO can be changed at run time to 256, 512 or 1024 bits. The host writes whole 8-bit or 16-bit words. The decoder pulls one 4-bit or 8-bit sample per request. In stereo mode each request takes one sample from both channels.

Three status outputs report the FIFO that the host currently addresses: empty, more than half full, and full. Each output has its own polarity bit. In stereo mode a channel select input chooses which FIFO takes the host's writes and which FIFO drives the status outputs. A start strobe marks the first time since reset that any active FIFO fills past its half mark, and the decoder uses it to begin playback. A read request that finds too little data raises an underrun pulse.

Top module: `stereo_sample_buffer`

## Requirements
- R1: `capSel` sets the capacity of each FIFO: 0 gives 256 bits, 1 gives 512 bits, and 2 or 3 give 1024 bits. The limit takes effect at once for both the flags and write acceptance.
- R2: The raw empty flag of a FIFO is 1 exactly when that FIFO holds no bits.
- R3: The raw mid flag is 1 exactly when the stored bit count is strictly greater than half of the configured capacity.
- R4: The raw full flag is 1 when the stored bits reach the capacity. A write that needs more bits than are free is dropped entirely, and no part of it is stored.
- R5: `playStart` is high during the single cycle after the edge at which the raw mid flag of the left FIFO, or of the right FIFO in stereo mode, is first set since reset. It does not rise again until the next reset.
- R6: Each status output equals its raw flag XOR its polarity bit (`polEmpty`, `polMid`, `polFull`), so a polarity bit of 1 makes that output active low.
- R7: With `stereoEn`=1, `chanSel`=1 selects the right FIFO and 0 selects the left FIFO, both for writes and for the status outputs. With `stereoEn`=0, the left FIFO is always used and `chanSel` has no effect.
- R8: A write with `wrWide`=1 stores all of `wrData[15:0]`. With `wrWide`=0 it stores only `wrData[7:0]`. Nibbles are stored lowest nibble first.
- R9: A request with `sampleWide`=1 pops 8 bits, and the oldest nibble goes in bits [3:0]. With `sampleWide`=0 it pops 4 bits, zero-extended. The result appears on `rdDataL` (and on `rdDataR` in stereo mode) after the edge that accepts the request. In stereo mode both FIFOs pop.
- R10: A request finds a FIFO short when that FIFO holds fewer bits than one sample. The short FIFO does not pop, and `underrun` is high for the cycle that follows.
- R11: Reset empties both FIFOs. After reset the raw flags read empty=1, mid=0 and full=0, both read data outputs are 0, `underrun` is 0 and `playStart` is 0.
- R12: A write and a read can arrive in the same cycle. Each is judged against the fill level from before that cycle, and both take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stereoEn | input | 1 | 1 selects stereo (two FIFOs), 0 selects mono |
| capSel | input | 2 | Capacity select per FIFO |
| polEmpty | input | 1 | 1 makes the empty output active low |
| polMid | input | 1 | 1 makes the mid output active low |
| polFull | input | 1 | 1 makes the full output active low |
| wrEn | input | 1 | Write strobe, one word per cycle |
| wrWide | input | 1 | 1 selects a 16-bit write, 0 an 8-bit write |
| chanSel | input | 1 | Stereo channel select (1 selects right) |
| wrData | input | 16 | Write word |
| rdReq | input | 1 | Sample request from the decoder |
| sampleWide | input | 1 | 1 selects an 8-bit sample, 0 a 4-bit sample |
| rdDataL | output | 8 | Sample from the left (mono) FIFO |
| rdDataR | output | 8 | Sample from the right FIFO |
| underrun | output | 1 | Pulse after a request that found a FIFO short |
| emptyOut | output | 1 | Empty status of the selected FIFO |
| midOut | output | 1 | Over-half status of the selected FIFO |
| fullOut | output | 1 | Full status of the selected FIFO |
| playStart | output | 1 | First over-half crossing since reset |

## Verification
The hardest states to reach are a FIFO that holds exactly one byte less than its capacity, and the same FIFO when a write and a read land in one cycle. From the ports alone, these are where a dropped partial write and the use of the pre-cycle fill level become visible. The stimulus reaches them by filling with 16-bit words, then topping up with 8-bit writes to leave exactly 8 bits free. It then offers a 16-bit write that must be refused, and finally issues combined write-and-read cycles against a full FIFO. A software model built from queues predicts every popped nibble, so a refused write that left a partial store would show up as misordered data later on.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int unsigned NUM_CH = 2;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic [NUM_CH-1:0] push;
    logic              pushWide;
    logic [NUM_CH-1:0] pop;
    logic              popWide;
  } sbufStrobe_t;
endpackage

// File: rtl/sbuf_store.sv
module sbuf_store
  import sbuf_pkg::*;
#(
  parameter int unsigned MAX_NIB = 256,
  parameter int unsigned CW      = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sbufStrobe_t                    stb,
  input  logic [15:0]                    wrData,
  output logic [NUM_CH-1:0][CW-1:0]      cnt,
  output logic [NUM_CH-1:0][7:0]         rdData
);
  localparam int unsigned AW = $clog2(MAX_NIB);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [3:0]    mem [MAX_NIB];
    logic [AW-1:0] wrPtr, rdPtr;
    logic [CW-1:0] level, inN, outN;

    assign inN  = stb.push[c] ? (stb.pushWide ? CW'(4) : CW'(2)) : '0;
    assign outN = stb.pop[c]  ? (stb.popWide  ? CW'(2) : CW'(1)) : '0;
    assign cnt[c] = level;

    always_ff @(posedge clk) begin
      for (int i = 0; i < 4; i++) begin
        if (stb.push[c] && (i < 2 || stb.pushWide))
          mem[wrPtr + AW'(i)] <= wrData[4*i +: 4];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wrPtr     <= '0;
        rdPtr     <= '0;
        level     <= '0;
        rdData[c] <= '0;
      end else begin
        wrPtr <= wrPtr + inN[AW-1:0];
        rdPtr <= rdPtr + outN[AW-1:0];
        level <= level + inN - outN;
        if (stb.pop[c])
          rdData[c] <= stb.popWide ? {mem[rdPtr + AW'(1)], mem[rdPtr]}
                                   : {4'b0000, mem[rdPtr]};
      end
    end

    // R4: storage never holds more than its physical depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(MAX_NIB));
    // R10: control never pops a channel that lacks a whole sample
    a_r10_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      stb.pop[c] |-> level >= (stb.popWide ? CW'(2) : CW'(1)));
  end
endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int unsigned MAX_NIB = 256,
  parameter int unsigned CW      = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stereoEn,
  input  logic [1:0]                capSel,
  input  logic                      polEmpty,
  input  logic                      polMid,
  input  logic                      polFull,
  input  logic                      wrEn,
  input  logic                      wrWide,
  input  logic                      chanSel,
  input  logic                      rdReq,
  input  logic                      sampleWide,
  input  logic [NUM_CH-1:0][CW-1:0] cnt,
  output sbufStrobe_t               stb,
  output logic                      emptyOut,
  output logic                      midOut,
  output logic                      fullOut,
  output logic                      playStart,
  output logic                      underrun
);
  logic [CW-1:0] capNib, halfNib, curCnt, freeN, needW, needR;
  logic          tgt, okL, okR, midAny, started;
  logic          emptyRaw, midRaw, fullRaw;

  always_comb begin
    case (capSel)
      2'd0:    capNib = CW'(MAX_NIB / 4);
      2'd1:    capNib = CW'(MAX_NIB / 2);
      default: capNib = CW'(MAX_NIB);
    endcase
  end

  assign halfNib = capNib >> 1;
  assign tgt     = stereoEn & chanSel;
  assign curCnt  = cnt[tgt];
  assign freeN   = (curCnt >= capNib) ? '0 : capNib - curCnt;
  assign needW   = wrWide ? CW'(4) : CW'(2);
  assign needR   = sampleWide ? CW'(2) : CW'(1);
  assign okL     = cnt[0] >= needR;
  assign okR     = cnt[1] >= needR;

  always_comb begin
    stb          = '0;
    stb.push[tgt] = wrEn && (freeN >= needW);
    stb.pushWide = wrWide;
    stb.pop[0]   = rdReq && okL;
    stb.pop[1]   = rdReq && stereoEn && okR;
    stb.popWide  = sampleWide;
  end

  assign emptyRaw = curCnt == '0;
  assign midRaw   = curCnt > halfNib;
  assign fullRaw  = curCnt >= capNib;
  assign emptyOut = emptyRaw ^ polEmpty;
  assign midOut   = midRaw ^ polMid;
  assign fullOut  = fullRaw ^ polFull;

  assign midAny    = (cnt[0] > halfNib) || (stereoEn && (cnt[1] > halfNib));
  assign playStart = midAny && !started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (midAny) started <= 1'b1;
      underrun <= rdReq && (!okL || (stereoEn && !okR));
    end
  end

  // R4: a write into a full FIFO with no read leaves its level unchanged
  a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !rdReq && fullRaw) |=> cnt[$past(tgt)] == $past(curCnt));
  // R10: a request on an empty left FIFO always reports underrun
  a_r10_underrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && cnt[0] == '0) |=> underrun);
  // R5: the start strobe lasts one cycle
  a_r5_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    playStart |=> !playStart);
endmodule

// File: rtl/stereo_sample_buffer.sv
module stereo_sample_buffer
  import sbuf_pkg::*;
#(
  parameter int unsigned MAX_BITS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stereoEn,
  input  logic [1:0]  capSel,
  input  logic        polEmpty,
  input  logic        polMid,
  input  logic        polFull,
  input  logic        wrEn,
  input  logic        wrWide,
  input  logic        chanSel,
  input  logic [15:0] wrData,
  input  logic        rdReq,
  input  logic        sampleWide,
  output logic [7:0]  rdDataL,
  output logic [7:0]  rdDataR,
  output logic        underrun,
  output logic        emptyOut,
  output logic        midOut,
  output logic        fullOut,
  output logic        playStart
);
  localparam int unsigned MAX_NIB = MAX_BITS / 4;
  localparam int unsigned CW      = $clog2(MAX_NIB) + 1;

  sbufStrobe_t               stb;
  logic [NUM_CH-1:0][CW-1:0] cnt;
  logic [NUM_CH-1:0][7:0]    rdData;

  sbuf_ctrl #(.MAX_NIB(MAX_NIB), .CW(CW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .stereoEn(stereoEn), .capSel(capSel),
    .polEmpty(polEmpty), .polMid(polMid), .polFull(polFull),
    .wrEn(wrEn), .wrWide(wrWide), .chanSel(chanSel),
    .rdReq(rdReq), .sampleWide(sampleWide), .cnt(cnt), .stb(stb),
    .emptyOut(emptyOut), .midOut(midOut), .fullOut(fullOut),
    .playStart(playStart), .underrun(underrun)
  );

  sbuf_store #(.MAX_NIB(MAX_NIB), .CW(CW)) i_store (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData),
    .cnt(cnt), .rdData(rdData)
  );

  assign rdDataL = rdData[0];
  assign rdDataR = rdData[1];
endmodule

// File: tb/test_stereo_sample_buffer.sv
`timescale 1ns/1ps
module test_stereo_sample_buffer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, stereoEn, polEmpty, polMid, polFull, wrEn, wrWide, chanSel;
  logic rdReq, sampleWide, underrun, emptyOut, midOut, fullOut, playStart;
  logic [1:0] capSel;
  logic [15:0] wrData;
  logic [7:0] rdDataL, rdDataR;

  stereo_sample_buffer i_stereo_sample_buffer (.*);

  int nChecks = 0, nFails = 0;
  logic [3:0] qL[$], qR[$];
  bit mStarted = 0;

  function automatic int capNibM();
    return capSel == 2'd0 ? 64 : capSel == 2'd1 ? 128 : 256;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Expected status outputs from the model's level of the displayed FIFO
  task automatic chkFlags(string req);
    int sz = (stereoEn && chanSel) ? qR.size() : qL.size();
    check({req, " empty"}, emptyOut, int'(sz == 0) ^ int'(polEmpty));
    check({req, " mid"},   midOut,   int'(sz > capNibM() / 2) ^ int'(polMid));
    check({req, " full"},  fullOut,  int'(sz >= capNibM()) ^ int'(polFull));
  endtask

  // Driver: apply a write (optionally with a read) and update the scoreboard
  task automatic xfer(bit doWr, bit ch, bit wide, logic [15:0] d,
                      bit doRd, bit sw, string req);
    bit useR = stereoEn && ch;
    int need = wide ? 4 : 2;
    int rneed = sw ? 2 : 1;
    int szW, expL, expR;
    bit accW, shortL, shortR;
    @(negedge clk);
    wrEn = doWr; chanSel = ch; wrWide = wide; wrData = d;
    rdReq = doRd; sampleWide = sw;
    szW = useR ? qR.size() : qL.size();
    accW = doWr && (capNibM() - szW >= need);
    shortL = qL.size() < rneed;
    shortR = stereoEn && (qR.size() < rneed);
    expL = rdDataL; expR = rdDataR;
    if (doRd && !shortL) begin
      expL = sw ? {qL[1], qL[0]} : {4'b0, qL[0]};
      for (int i = 0; i < rneed; i++) void'(qL.pop_front());
    end
    if (doRd && stereoEn && !shortR) begin
      expR = sw ? {qR[1], qR[0]} : {4'b0, qR[0]};
      for (int i = 0; i < rneed; i++) void'(qR.pop_front());
    end
    if (accW)
      for (int i = 0; i < need; i++)
        if (useR) qR.push_back(d[4*i +: 4]); else qL.push_back(d[4*i +: 4]);
    @(negedge clk);
    wrEn = 0; rdReq = 0;
    // Monitor side: compare what the design produced
    if (doRd) begin
      check({req, " R9 rdDataL"}, rdDataL, expL);
      if (stereoEn) check({req, " R9 rdDataR"}, rdDataR, expR);
      check({req, " R10 underrun"}, underrun, int'(shortL || shortR));
    end
    if (doWr) begin
      bit midAny = (qL.size() > capNibM() / 2) ||
                   (stereoEn && qR.size() > capNibM() / 2);
      check({req, " R5 playStart"}, playStart, int'(midAny && !mStarted));
      if (midAny) mStarted = 1;
    end
  endtask

  task automatic wr(bit ch, bit wide, logic [15:0] d, string req);
    xfer(1, ch, wide, d, 0, 0, req);
  endtask
  task automatic rd(bit sw, string req);
    xfer(0, chanSel, 0, 16'h0, 1, sw, req);
  endtask
  task automatic drain(string req);
    for (int k = 0; k < 300 && (qL.size() > 0 || (stereoEn && qR.size() > 0)); k++)
      rd(k[0], req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; stereoEn = 0; capSel = 0; polEmpty = 0; polMid = 0; polFull = 0;
    wrEn = 0; wrWide = 0; chanSel = 0; wrData = 0; rdReq = 0; sampleWide = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 emptyOut", emptyOut, 1);
    check("R11 midOut", midOut, 0);
    check("R11 fullOut", fullOut, 0);
    check("R11 rdDataL", rdDataL, 0);
    check("R11 rdDataR", rdDataR, 0);
    check("R11 underrun", underrun, 0);
    check("R11 playStart", playStart, 0);

    // Mono, 256 bits: R3 threshold, R5 first crossing
    for (int i = 0; i < 8; i++) wr(0, 1, 16'hA000 + 16'(i * 16'h0123), "R8 word");
    chkFlags("R3 at half");
    wr(0, 1, 16'h5A3C, "R5 crossing");
    chkFlags("R3 over half");
    for (int i = 9; i < 15; i++) wr(0, 1, 16'h1000 + 16'(i * 16'h0345), "R8 word");
    wr(0, 0, 16'hFF96, "R8 byte");
    chkFlags("R4 one byte free");
    wr(0, 1, 16'hDEAD, "R4 partial fit refused");
    chkFlags("R4 after refusal");
    wr(0, 0, 16'h0071, "R4 last byte");
    chkFlags("R4 full");
    wr(0, 0, 16'h00EE, "R4 write when full");
    chkFlags("R4 still full");
    polEmpty = 1; polMid = 1; polFull = 1;
    @(negedge clk);
    chkFlags("R6 inverted full");
    drain("R9 mono drain");
    chkFlags("R6 inverted empty");
    polEmpty = 0; polMid = 0; polFull = 0;
    @(negedge clk);
    chkFlags("R2 empty");
    rd(0, "R10 empty nibble");
    wr(0, 0, 16'h00C4, "R8 byte");
    rd(0, "R9 nibble");
    rd(1, "R10 byte with one nibble");
    rd(0, "R9 last nibble");
    // R7: chanSel ignored in mono
    wr(1, 0, 16'h0039, "R7 mono chanSel");
    chkFlags("R7 mono flags");
    rd(1, "R7 mono goes left");

    // Stereo routing
    stereoEn = 1;
    for (int i = 0; i < 3; i++) wr(1, 1, 16'h7E10 + 16'(i), "R7 right write");
    chkFlags("R7 right shown");
    chanSel = 0;
    @(negedge clk);
    chkFlags("R7 left shown empty");
    rd(1, "R10 stereo left short");
    wr(0, 1, 16'hB2C3, "R7 left write");
    drain("R9 stereo drain");

    // Capacity 512 then 1024
    capSel = 2'd1;
    for (int i = 0; i < 16; i++) wr(0, 1, 16'h3300 + 16'(i * 7), "R1 fill 512");
    chkFlags("R1 512 at half");
    wr(0, 1, 16'h4455, "R5 no second start");
    chkFlags("R1 512 over half");
    for (int i = 17; i < 32; i++) wr(0, 1, 16'h6000 + 16'(i), "R1 fill 512");
    chkFlags("R1 512 full");
    capSel = 2'd3;
    @(negedge clk);
    chkFlags("R1 1024 not full");
    for (int i = 32; i < 64; i++) wr(0, 1, 16'h9000 + 16'(i * 3), "R1 fill 1024");
    chkFlags("R1 1024 full");
    // R12: simultaneous write and read against pre-cycle level
    xfer(1, 0, 1, 16'h1234, 1, 1, "R12 full write+read");
    chkFlags("R12 one byte free");
    xfer(1, 0, 1, 16'h5678, 1, 0, "R12 word too big");
    xfer(1, 0, 0, 16'h00AB, 1, 1, "R12 byte fits");
    chkFlags("R12 level kept");
    drain("R12 drain");
    chkFlags("R2 final empty");
    summary();
  end
endmodule